// File: doc/BRIEF.md
# Hint-Aware Cache Replacement Controller

This block holds the tags and the replacement state of a 4-way set-associative data cache level and decides, for every request, what the cache does with it. Each request carries an address, a read/write flag, a 2-bit coherence scope and a 3-bit temporal hint. Scope values are ordered by width: 0 is one compute unit, 1 is one shader engine, 2 is the whole device and 3 is the system. The parameter `LEVEL_SCOPE` gives the widest scope this level can serve. A request with a wider scope goes past the level untouched and is sent on to the next level.

For requests that are served here, the block looks up the tags of the indexed set. On a hit it updates the true-LRU order according to the hint. On a miss it chooses a victim way, installs the new tag there and places it in LRU order according to the hint. The miss is then sent to the next level as a fill request. Hints are advisory, so the parameter `HINTS_EN = 0` turns every hint into a regular access.

The response and the next-level request are both registered and appear one cycle after the request. Back-to-back requests always see the state left by the request before them.

Top module: `hint_cache_ctrl`

## Requirements
- R1: A request whose scope exceeds `LEVEL_SCOPE` (default 1) responds with bypass=1, hit=0 and way=0. It raises the next-level request with alloc=0 and changes no tag, valid or LRU state. Scopes less than or equal to `LEVEL_SCOPE` are looked up normally.
- R2: Every accepted request gets exactly one response in the following cycle. A served request whose tag matches a valid way of its set reports hit=1 and that way, and raises no next-level request.
- R3: A served miss installs its tag and reports the way it used. That way is the lowest-numbered invalid way if one exists, otherwise the victim way. The next-level request carries the request address and write flag and has alloc=1. A later request to the same line hits in that way.
- R4: A hit with hint 0 (regular) or 2 (high-temporal) makes the line most-recently-used. A miss with those hints also places the new line at most-recently-used.
- R5: A hit with hint 1 (non-temporal) keeps the line resident and leaves the LRU order of the set unchanged.
- R6: A hit with hint 3 (last use) makes the line least-recently-used, so it is the next victim of its set.
- R7: A miss with hint 1 (non-temporal) places the new line at the least-recently-used position.
- R8: A line filled with hint 2 is protected for the next `PROTECT_N` (default 4) served accesses to its set. While it is protected, the victim is the oldest unprotected valid way. When all ways are protected, the victim is the plain LRU way.
- R9: Hint codes 4 to 7 behave exactly as hint 0. With `HINTS_EN = 0`, every hint behaves as hint 0.
- R10: After reset all lines are invalid, resp_valid_o and nl_valid_o are 0, and the initial LRU order of every set runs from way 0 (most recent) to way 3 (least recent).
- R11: The address is split into a line offset of `OFF_W` bits (default 6), then a set index of log2(`SETS`) bits (default 4), then the tag. Addresses that differ only in the offset hit the same line, and an equal tag in another set is a separate line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | ADDR_W | Request byte address |
| req_scope_i | input | 2 | Coherence scope: 0 unit, 1 engine, 2 device, 3 system |
| req_hint_i | input | 3 | Temporal hint: 0 regular, 1 non-temporal, 2 high-temporal, 3 last use |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| resp_valid_o | output | 1 | Response present |
| resp_hit_o | output | 1 | Tag matched at this level |
| resp_bypass_o | output | 1 | Request skipped this level because of its scope |
| resp_way_o | output | log2(WAYS) | Hit way or allocated way |
| nl_valid_o | output | 1 | Request to the next level (miss or bypass) |
| nl_addr_o | output | ADDR_W | Address sent to the next level |
| nl_write_o | output | 1 | Write flag sent to the next level |
| nl_alloc_o | output | 1 | Returning fill is allocated at this level |

## Verification
The bound checker checks the per-cycle rules on every cycle: one response per request, the exclusion between bypass and hit, that a miss is forwarded and a hit is not, that a served miss allocates, that a too-wide scope always bypasses, and that the address and write flag pass through. The effects of the hints on LRU order, the expiry of high-temporal protection, the fall-back when every way is protected, and the fact that a bypass leaves no trace on the set only show up over a sequence of accesses to one set. The bench scenarios therefore build known LRU orders and then observe which way the next miss evicts.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam logic [2:0] HINT_REG  = 3'd0;
  localparam logic [2:0] HINT_NT   = 3'd1;
  localparam logic [2:0] HINT_HT   = 3'd2;
  localparam logic [2:0] HINT_LAST = 3'd3;

  typedef enum logic [1:0] {
    AGE_KEEP = 2'd0,
    AGE_MRU  = 2'd1,
    AGE_LRU  = 2'd2
  } age_op_e;

  typedef struct packed {
    logic    bypass;
    age_op_e hit_op;
    age_op_e fill_op;
    logic    protect;
  } policy_t;
endpackage

// File: rtl/hcr_policy.sv
module hcr_policy
  import hcr_pkg::*;
#(
  parameter int unsigned LEVEL_SCOPE = 1,
  parameter bit          HINTS_EN    = 1'b1
) (
  input  logic [1:0] scope_i,
  input  logic [2:0] hint_i,
  output policy_t    pol_o
);
  logic bypass;
  assign bypass = scope_i > 2'(LEVEL_SCOPE);

  generate
    if (HINTS_EN) begin : g_hints
      always_comb begin
        pol_o = '{bypass: bypass, hit_op: AGE_MRU, fill_op: AGE_MRU, protect: 1'b0};
        case (hint_i)
          HINT_NT: begin
            pol_o.hit_op  = AGE_KEEP;
            pol_o.fill_op = AGE_LRU;
          end
          HINT_HT:   pol_o.protect = 1'b1;
          HINT_LAST: pol_o.hit_op  = AGE_LRU;
          default: ;
        endcase
      end
    end else begin : g_flat
      logic [2:0] hint_unused;
      assign hint_unused = hint_i;
      always_comb pol_o = '{bypass: bypass, hit_op: AGE_MRU, fill_op: AGE_MRU, protect: 1'b0};
    end
  endgenerate
endmodule

// File: rtl/hcr_tag_array.sv
module hcr_tag_array #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 22,
  parameter int unsigned CNT_W = 3,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned AGE_W = $clog2(WAYS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [SET_W-1:0]                  rd_idx_i,
  output logic [WAYS-1:0]                   rd_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]        rd_tag_o,
  output logic [WAYS-1:0][AGE_W-1:0]        rd_age_o,
  output logic [WAYS-1:0][CNT_W-1:0]        rd_prot_o,
  input  logic                              upd_en_i,
  input  logic [SET_W-1:0]                  upd_idx_i,
  input  logic [WAYS-1:0][AGE_W-1:0]        upd_age_i,
  input  logic [WAYS-1:0][CNT_W-1:0]        upd_prot_i,
  input  logic                              ins_en_i,
  input  logic [AGE_W-1:0]                  ins_way_i,
  input  logic [TAG_W-1:0]                  ins_tag_i
);
  function automatic logic [WAYS-1:0][AGE_W-1:0] init_age();
    logic [WAYS-1:0][AGE_W-1:0] r;
    for (int w = 0; w < WAYS; w++) r[w] = AGE_W'(w);
    return r;
  endfunction

  logic [WAYS-1:0]                 valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]      tag_q   [SETS];
  logic [WAYS-1:0][AGE_W-1:0]      age_q   [SETS];
  logic [WAYS-1:0][CNT_W-1:0]      prot_q  [SETS];

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_age_o   = age_q[rd_idx_i];
  assign rd_prot_o  = prot_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        age_q[s]   <= init_age();
        prot_q[s]  <= '0;
      end
    end else begin
      if (upd_en_i) begin
        age_q[upd_idx_i]  <= upd_age_i;
        prot_q[upd_idx_i] <= upd_prot_i;
      end
      if (ins_en_i) valid_q[upd_idx_i][ins_way_i] <= 1'b1;
    end
  end

  // tags need no reset: valid bits qualify them
  always_ff @(posedge clk_i) begin
    if (ins_en_i) tag_q[upd_idx_i][ins_way_i] <= ins_tag_i;
  end
endmodule

// File: rtl/hcr_lru_update.sv
module hcr_lru_update
  import hcr_pkg::*;
#(
  parameter int unsigned WAYS      = 4,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned PROTECT_N = 4,
  localparam int unsigned AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][AGE_W-1:0]  age_i,
  input  logic [WAYS-1:0][CNT_W-1:0]  prot_i,
  input  logic                        hit_i,
  input  logic [AGE_W-1:0]            hit_way_i,
  input  age_op_e                     op_i,
  input  logic                        protect_i,
  output logic [AGE_W-1:0]            victim_o,
  output logic [WAYS-1:0][AGE_W-1:0]  age_o,
  output logic [WAYS-1:0][CNT_W-1:0]  prot_o
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic             inv_any, unp_any;
  logic [AGE_W-1:0] inv_way, unp_way, unp_age, lru_way;
  logic [AGE_W-1:0] tgt, tgt_age;

  // victim: lowest invalid, else oldest unprotected, else plain LRU
  always_comb begin
    inv_any = 1'b0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        inv_any = 1'b1;
        inv_way = AGE_W'(w);
      end
    end
    unp_any = 1'b0;
    unp_way = '0;
    unp_age = '0;
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (prot_i[w] == '0 && (!unp_any || age_i[w] > unp_age)) begin
        unp_any = 1'b1;
        unp_way = AGE_W'(w);
        unp_age = age_i[w];
      end
      if (age_i[w] == OLDEST) lru_way = AGE_W'(w);
    end
    victim_o = inv_any ? inv_way : (unp_any ? unp_way : lru_way);
  end

  assign tgt     = hit_i ? hit_way_i : victim_o;
  assign tgt_age = age_i[tgt];

  always_comb begin
    age_o = age_i;
    for (int w = 0; w < WAYS; w++) begin
      unique case (op_i)
        AGE_MRU: begin
          if (AGE_W'(w) == tgt)         age_o[w] = '0;
          else if (age_i[w] < tgt_age)  age_o[w] = age_i[w] + 1'b1;
        end
        AGE_LRU: begin
          if (AGE_W'(w) == tgt)         age_o[w] = OLDEST;
          else if (age_i[w] > tgt_age)  age_o[w] = age_i[w] - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      prot_o[w] = (prot_i[w] != '0) ? prot_i[w] - 1'b1 : '0;
    if (!hit_i) prot_o[tgt] = protect_i ? CNT_W'(PROTECT_N) : '0;
  end
endmodule

// File: rtl/hint_cache_ctrl.sv
module hint_cache_ctrl
  import hcr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned OFF_W       = 6,
  parameter int unsigned SETS        = 16,
  parameter int unsigned WAYS        = 4,
  parameter int unsigned LEVEL_SCOPE = 1,
  parameter int unsigned PROTECT_N   = 4,
  parameter bit          HINTS_EN    = 1'b1,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned TAG_W = ADDR_W - OFF_W - SET_W,
  localparam int unsigned CNT_W = $clog2(PROTECT_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_scope_i,
  input  logic [2:0]        req_hint_i,
  input  logic              req_write_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_bypass_o,
  output logic [WAY_W-1:0]  resp_way_o,
  output logic              nl_valid_o,
  output logic [ADDR_W-1:0] nl_addr_o,
  output logic              nl_write_o,
  output logic              nl_alloc_o
);
  policy_t                    pol;
  logic [SET_W-1:0]           idx;
  logic [TAG_W-1:0]           tag;
  logic [WAYS-1:0]            set_valid, hit_vec;
  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  logic [WAYS-1:0][WAY_W-1:0] set_age, age_nxt;
  logic [WAYS-1:0][CNT_W-1:0] set_prot, prot_nxt;
  logic [WAY_W-1:0]           hit_way, victim;
  logic                       hit, served, miss;

  assign idx = req_addr_i[OFF_W +: SET_W];
  assign tag = req_addr_i[ADDR_W-1 -: TAG_W];

  hcr_policy #(.LEVEL_SCOPE(LEVEL_SCOPE), .HINTS_EN(HINTS_EN)) u_policy (
    .scope_i(req_scope_i),
    .hint_i (req_hint_i),
    .pol_o  (pol)
  );

  hcr_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (idx),
    .rd_valid_o(set_valid),
    .rd_tag_o  (set_tag),
    .rd_age_o  (set_age),
    .rd_prot_o (set_prot),
    .upd_en_i  (served),
    .upd_idx_i (idx),
    .upd_age_i (age_nxt),
    .upd_prot_i(prot_nxt),
    .ins_en_i  (miss),
    .ins_way_i (victim),
    .ins_tag_i (tag)
  );

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = set_valid[w] && (set_tag[w] == tag);
    end
  endgenerate

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign served = req_valid_i && !pol.bypass;
  assign hit    = served && (|hit_vec);
  assign miss   = served && !(|hit_vec);

  hcr_lru_update #(.WAYS(WAYS), .CNT_W(CNT_W), .PROTECT_N(PROTECT_N)) u_lru (
    .valid_i  (set_valid),
    .age_i    (set_age),
    .prot_i   (set_prot),
    .hit_i    (|hit_vec),
    .hit_way_i(hit_way),
    .op_i     ((|hit_vec) ? pol.hit_op : pol.fill_op),
    .protect_i(pol.protect),
    .victim_o (victim),
    .age_o    (age_nxt),
    .prot_o   (prot_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o  <= 1'b0;
      resp_hit_o    <= 1'b0;
      resp_bypass_o <= 1'b0;
      resp_way_o    <= '0;
      nl_valid_o    <= 1'b0;
      nl_addr_o     <= '0;
      nl_write_o    <= 1'b0;
      nl_alloc_o    <= 1'b0;
    end else begin
      resp_valid_o  <= req_valid_i;
      resp_hit_o    <= hit;
      resp_bypass_o <= req_valid_i && pol.bypass;
      resp_way_o    <= hit ? hit_way : (miss ? victim : '0);
      nl_valid_o    <= req_valid_i && !hit;
      nl_addr_o     <= req_addr_i;
      nl_write_o    <= req_write_i;
      nl_alloc_o    <= miss;
    end
  end
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LEVEL_SCOPE = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_scope_i,
  input logic              req_write_i,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic              resp_bypass_o,
  input logic              nl_valid_o,
  input logic [ADDR_W-1:0] nl_addr_o,
  input logic              nl_write_o,
  input logic              nl_alloc_o
);
  a_r2_one_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o && !nl_valid_o);
  a_r1_wide_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_scope_i > 2'(LEVEL_SCOPE)) |=> resp_bypass_o);
  a_r1_narrow_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_scope_i <= 2'(LEVEL_SCOPE)) |=> !resp_bypass_o);
  a_r1_bypass_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_bypass_o) |-> (!resp_hit_o && nl_valid_o && !nl_alloc_o));
  a_r2_hit_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_hit_o) |-> !nl_valid_o);
  a_r3_miss_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o && !resp_bypass_o) |-> (nl_valid_o && nl_alloc_o));
  a_r3_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (nl_addr_o == $past(req_addr_i)) && (nl_write_o == $past(req_write_i)));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !nl_valid_o && !resp_hit_o);
endmodule

bind hint_cache_ctrl hcr_checker #(.ADDR_W(ADDR_W), .LEVEL_SCOPE(LEVEL_SCOPE)) u_hcr_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .req_scope_i  (req_scope_i),
  .req_write_i  (req_write_i),
  .resp_valid_o (resp_valid_o),
  .resp_hit_o   (resp_hit_o),
  .resp_bypass_o(resp_bypass_o),
  .nl_valid_o   (nl_valid_o),
  .nl_addr_o    (nl_addr_o),
  .nl_write_o   (nl_write_o),
  .nl_alloc_o   (nl_alloc_o)
);

// File: tb/tb_hint_cache_ctrl.sv
`timescale 1ns/1ps
module tb_hint_cache_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_scope = '0;
  logic [2:0]  req_hint = '0;
  logic        req_write = 1'b0;
  logic        resp_valid, resp_hit, resp_bypass, nl_valid, nl_write, nl_alloc;
  logic [1:0]  resp_way;
  logic [31:0] nl_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hint_cache_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_scope_i(req_scope),
    .req_hint_i(req_hint), .req_write_i(req_write),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_bypass_o(resp_bypass),
    .resp_way_o(resp_way), .nl_valid_o(nl_valid), .nl_addr_o(nl_addr),
    .nl_write_o(nl_write), .nl_alloc_o(nl_alloc)
  );

  typedef struct {
    logic        hit;
    logic        byp;
    logic [1:0]  way;
    logic [31:0] addr;
    logic        wr;
    string       req;
  } exp_t;

  exp_t sb[$];

  function automatic logic [31:0] mk(input int t, input int s, input int off);
    return {22'(t), 4'(s), 6'(off)};
  endfunction

  task automatic send(input int t, input int s, input int off, input logic [1:0] sc,
                      input logic [2:0] h, input logic wr, input logic ehit,
                      input logic ebyp, input logic [1:0] eway, input string req);
    exp_t e;
    @(negedge clk);
    e.hit = ehit; e.byp = ebyp; e.way = eway; e.addr = mk(t, s, off); e.wr = wr; e.req = req;
    sb.push_back(e);
    req_valid = 1'b1;
    req_addr  = e.addr;
    req_scope = sc;
    req_hint  = h;
    req_write = wr;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pop and compare one expected item per response
  initial begin
    forever begin
      @(negedge clk);
      if (resp_valid) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected response hit=%0b way=%0d, expected none", resp_hit, resp_way);
        end else begin
          exp_t e;
          logic [5:0] got, want;
          e = sb.pop_front();
          got  = {resp_hit, resp_bypass, resp_way, nl_valid, nl_alloc};
          want = {e.hit, e.byp, e.way, !e.hit, !e.hit && !e.byp};
          if (got !== want ||
              (nl_valid && (nl_addr !== e.addr || nl_write !== e.wr))) begin
            errors++;
            $display("FAIL %s: {hit,byp,way,nl,alloc}=%b addr=%h wr=%b, expected %b addr=%h wr=%b",
                     e.req, got, nl_addr, nl_write, want, e.addr, e.wr);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0 || nl_valid !== 1'b0 || resp_hit !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset outputs valid=%b nl=%b hit=%b, expected 0 0 0", resp_valid, nl_valid, resp_hit);
    end

    // R3 / R11: allocation, offset aliasing, set separation
    send(10, 1, 0,  0, 0, 0, 0, 0, 0, "R3");
    send(10, 1, 8,  0, 0, 1, 1, 0, 0, "R11");
    send(10, 2, 0,  0, 0, 0, 0, 0, 0, "R11");
    // set 3: fill four ways, R10 order gives ways 0..3
    send(1, 3, 0, 0, 0, 0, 0, 0, 0, "R10");
    send(2, 3, 0, 0, 0, 0, 0, 0, 1, "R3");
    send(3, 3, 0, 0, 0, 0, 0, 0, 2, "R3");
    send(4, 3, 0, 0, 0, 1, 0, 0, 3, "R3");
    send(1, 3, 4, 0, 1, 0, 1, 0, 0, "R5");   // non-temporal hit keeps order
    send(5, 3, 0, 0, 0, 0, 0, 0, 0, "R5");   // way 0 still oldest
    send(2, 3, 0, 0, 0, 0, 1, 0, 1, "R4");
    send(6, 3, 0, 0, 0, 0, 0, 0, 2, "R4");
    send(5, 3, 0, 0, 3, 0, 1, 0, 0, "R6");   // last use demotes way 0
    send(7, 3, 0, 0, 0, 0, 0, 0, 0, "R6");
    send(8, 3, 0, 0, 1, 0, 0, 0, 3, "R7");   // non-temporal fill at LRU
    send(9, 3, 0, 0, 0, 0, 0, 0, 3, "R7");   // evicts it right away
    send(8, 3, 0, 0, 0, 0, 0, 0, 1, "R7");
    // R1: scope wider than engine bypasses with no state change
    send(9, 3, 0,  2, 0, 0, 0, 1, 0, "R1");
    send(10, 3, 0, 3, 0, 1, 0, 1, 0, "R1");
    send(9, 3, 0,  1, 0, 0, 1, 0, 3, "R1");
    send(11, 3, 0, 0, 0, 0, 0, 0, 2, "R1");
    // R8: protection expiry
    send(1, 7, 0, 0, 2, 0, 0, 0, 0, "R8");
    send(2, 7, 0, 0, 0, 0, 0, 0, 1, "R8");
    send(3, 7, 0, 0, 0, 0, 0, 0, 2, "R8");
    send(4, 7, 0, 0, 0, 0, 0, 0, 3, "R8");
    send(5, 7, 0, 0, 0, 0, 0, 0, 1, "R8");   // way 0 protected
    send(6, 7, 0, 0, 0, 0, 0, 0, 0, "R8");   // protection expired
    // R8: all ways protected falls back to LRU
    send(1, 9, 0, 0, 2, 0, 0, 0, 0, "R8");
    send(2, 9, 0, 0, 2, 0, 0, 0, 1, "R8");
    send(3, 9, 0, 0, 2, 0, 0, 0, 2, "R8");
    send(4, 9, 0, 0, 2, 0, 0, 0, 3, "R8");
    send(5, 9, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R9: undefined hint code acts as regular
    send(1, 11, 0, 0, 0, 0, 0, 0, 0, "R9");
    send(2, 11, 0, 0, 0, 0, 0, 0, 1, "R9");
    send(3, 11, 0, 0, 0, 0, 0, 0, 2, "R9");
    send(4, 11, 0, 0, 0, 0, 0, 0, 3, "R9");
    send(1, 11, 0, 0, 5, 0, 1, 0, 0, "R9");
    send(5, 11, 0, 0, 0, 0, 0, 0, 1, "R9");
    idle();
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d responses missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule